// File: doc/BRIEF.md
# Bus Monitor Command Block Logger

This block sits passively beside a dual-redundant serial command/response bus and records traffic for a chosen set of remote terminals into memory. It sees a stream of already decoded 16-bit words, each marked as a sync word (command or status) or a data word and flagged when the decoder found a parity or sync fault. For each message whose first command addresses an enabled terminal, it fills one seven-word command block that the host has prepared in memory. Message data goes to a separate buffer named by a pointer inside the block. The block then follows the block's tail pointer, so the list of blocks and the data buffers can sit anywhere in memory.

The host builds a chain of blocks. In each block it sets the data pointer, the tail pointer and, if it wants to be told when the block is used, an interrupt request bit. It then presents the head address and raises the enable. The logger reads the three host fields when a message starts and marks the block active with an 8-bit time tag. It writes each data word as it arrives. When the message ends it writes back the command and status words and the final control word, and pulses the interrupt line if the host asked for one. A message ends when its last expected word arrives or when the bus stays quiet for a set number of cycles. Words on the bus are assumed to be at least six clock cycles apart, which holds for any practical clock against the bus bit rate.

Top module: `mon_logger`

## Requirements
- R1: A monitored message's command word 1 is written at block offset 1 and status word 1 at offset 4. The block offsets are 0 control, 1 command 1, 2 command 2, 3 data pointer, 4 status 1, 5 status 2, 6 tail pointer. Offsets 3 and 6 are only read.
- R2: The k-th data word of a message (k from 0) is written to address data pointer + k, in arrival order.
- R3: After a block is completed, the next monitored message uses the block at the address read from the previous block's tail pointer.
- R4: The expected data count is the command word's bits [4:0], where 0 means 32. At most that many data words are stored.
- R5: The first memory write of a monitored message is the control word at offset 0. Its layout is bits [15:8] the time base sampled on the clock edge that accepts command word 1, bit 2 activated = 1, bit 1 error = 0, bit 0 the interrupt request bit read from the block, and all other bits 0.
- R6: A receive command followed directly by a second sync word is a terminal-to-terminal transfer. Command 2 holds that word, status 1 the first status, and status 2 the final status. For all other transfers, command 2 and status 2 are written as zero.
- R7: A message is monitored only when bit A of the enable table is set, where A is command word 1 bits [15:11]. Otherwise the logger writes nothing and waits for a quiet gap of GAP_CYCLES cycles before it accepts a new command.
- R8: The final control word has the error bit set in four cases: a word carried the fault flag, a sync word came while data were still expected, extra data came after the count was reached, or the bus stayed quiet for GAP_CYCLES cycles before the message ended (missing status).
- R9: One cycle after the final control word write, the interrupt line pulses high for exactly one cycle if the block's interrupt request bit is set, and stays low otherwise.
- R10: Data-tagged words that arrive while no message is in progress cause no memory write.
- R11: While the enable is low, the logger makes no memory access, raises no interrupt and loads the head address. After the enable rises, the first monitored message fills the block at that head address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_en | input | 1 | Logger enable; while low the head address is loaded |
| list_head | input | ADDR_W | Address of the first command block |
| rt_enable | input | 32 | One enable bit per remote terminal address |
| time_base | input | 8 | Free-running time base sampled into the time tag |
| word_valid | input | 1 | A decoded word is present this cycle |
| word_sync | input | 1 | 1 = command/status sync word, 0 = data word |
| word_fault | input | 1 | Decoder found a parity or sync fault on this word |
| word_data | input | 16 | Decoded word contents |
| mem_re | output | 1 | Memory read strobe; data returns on the next cycle |
| mem_raddr | output | ADDR_W | Memory read address |
| mem_rdata | input | 16 | Memory read data, one cycle after mem_re |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | ADDR_W | Memory write address |
| mem_wdata | output | 16 | Memory write data |
| irq | output | 1 | One-cycle pulse on completion of a block that requests it |

## Verification
The hardest cases to reach are the endings where no closing word ever comes, such as a missing final status or a short data count. In these cases the block has to notice silence, not an event. The stimulus withholds the final status, or sends a status while data words are still owed. It then leaves the bus idle well beyond the quiet window. The scoreboard then expects the full write-back with the error bit set, the tail pointer followed, and the interrupt raised only when requested. A message to a disabled terminal is checked the same way: no write may appear, and the next monitored message must reuse the same block.

// File: rtl/mon_pkg.sv
package mon_pkg;

    localparam int WORD_W = 16;
    localparam int TT_W   = 8;
    localparam int RT_AW  = 5;
    localparam int RT_N   = 1 << RT_AW;

    // command block offsets (host reads these positions)
    localparam int OFS_CTRL = 0;
    localparam int OFS_CMD1 = 1;
    localparam int OFS_CMD2 = 2;
    localparam int OFS_DPTR = 3;
    localparam int OFS_STS1 = 4;
    localparam int OFS_STS2 = 5;
    localparam int OFS_TAIL = 6;

    // control word bit positions
    localparam int CB_IWA = 0;
    localparam int CB_ERR = 1;
    localparam int CB_ACT = 2;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SKIP, ST_F1, ST_F2, ST_F3, ST_F4,
        ST_FIRST, ST_STS1, ST_DATA, ST_STSF, ST_WB, ST_FIN
    } state_e;

    function automatic logic [5:0] wc_expand(input logic [4:0] f);
        return (f == 5'd0) ? 6'd32 : {1'b0, f};
    endfunction

    function automatic logic cmd_is_tx(input logic [WORD_W-1:0] w);
        return w[10];
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_word(input logic [TT_W-1:0] tt,
                                                   input logic act,
                                                   input logic err,
                                                   input logic iwa);
        logic [WORD_W-1:0] w;
        w = '0;
        w[WORD_W-1 -: TT_W] = tt;
        w[CB_ACT] = act;
        w[CB_ERR] = err;
        w[CB_IWA] = iwa;
        return w;
    endfunction

endpackage

// File: rtl/mon_rt_filter.sv
module mon_rt_filter
    import mon_pkg::*;
(
    input  logic [WORD_W-1:0] cmd_word,
    input  logic [RT_N-1:0]   enable_tbl,
    output logic              hit
);
    logic [RT_AW-1:0] rt_addr;

    always_comb begin
        rt_addr = cmd_word[WORD_W-1 -: RT_AW];
        hit     = enable_tbl[rt_addr];
    end
endmodule

// File: rtl/mon_gap_timer.sv
module mon_gap_timer #(
    parameter int GAP = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic kick,
    output logic expired
);
    localparam int CW = $clog2(GAP + 1);
    localparam logic [CW-1:0] LIMIT = CW'(GAP);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!arm || kick) begin
            cnt_d = '0;
        end else if (cnt_q != LIMIT) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == LIMIT);
endmodule

// File: rtl/mon_logger.sv
module mon_logger
    import mon_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int GAP_CYCLES = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mon_en,
    input  logic [ADDR_W-1:0] list_head,
    input  logic [RT_N-1:0]   rt_enable,
    input  logic [TT_W-1:0]   time_base,
    input  logic              word_valid,
    input  logic              word_sync,
    input  logic              word_fault,
    input  logic [WORD_W-1:0] word_data,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CMD1 = ADDR_W'(OFS_CMD1);
    localparam logic [ADDR_W-1:0] A_CMD2 = ADDR_W'(OFS_CMD2);
    localparam logic [ADDR_W-1:0] A_DPTR = ADDR_W'(OFS_DPTR);
    localparam logic [ADDR_W-1:0] A_STS1 = ADDR_W'(OFS_STS1);
    localparam logic [ADDR_W-1:0] A_STS2 = ADDR_W'(OFS_STS2);
    localparam logic [ADDR_W-1:0] A_TAIL = ADDR_W'(OFS_TAIL);

    typedef struct packed {
        state_e              st;
        logic [ADDR_W-1:0]   blk;
        logic [ADDR_W-1:0]   tail;
        logic [ADDR_W-1:0]   dptr;
        logic                iwa;
        logic [TT_W-1:0]     tt;
        logic [WORD_W-1:0]   c1;
        logic [WORD_W-1:0]   c2;
        logic [WORD_W-1:0]   s1;
        logic [WORD_W-1:0]   s2;
        logic                rtrt;
        logic [5:0]          cnt;
        logic                err;
        logic [2:0]          wbi;
        logic                mre;
        logic [ADDR_W-1:0]   raddr;
        logic                mwe;
        logic [ADDR_W-1:0]   waddr;
        logic [WORD_W-1:0]   wdata;
        logic                irq;
    } regs_t;

    regs_t q, d;

    logic       rt_hit;
    logic       gap_exp;
    logic       gap_arm;
    logic       fin_sts;
    logic [5:0] exp_n;
    logic       acc_data;
    logic       acc_sync;

    mon_rt_filter u_filter (
        .cmd_word   (word_data),
        .enable_tbl (rt_enable),
        .hit        (rt_hit)
    );

    assign gap_arm = (q.st == ST_SKIP) || (q.st == ST_FIRST) || (q.st == ST_STS1)
                  || (q.st == ST_DATA) || (q.st == ST_STSF);

    mon_gap_timer #(.GAP(GAP_CYCLES)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (gap_arm),
        .kick    (word_valid),
        .expired (gap_exp)
    );

    assign fin_sts  = !cmd_is_tx(q.c1);
    assign exp_n    = wc_expand(q.c1[4:0]);
    assign acc_data = word_valid && !word_sync;
    assign acc_sync = word_valid && word_sync;

    always_comb begin
        d     = q;
        d.mre = 1'b0;
        d.mwe = 1'b0;
        d.irq = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (acc_sync && rt_hit) begin
                    d.c1    = word_data;
                    d.c2    = '0;
                    d.s1    = '0;
                    d.s2    = '0;
                    d.rtrt  = 1'b0;
                    d.cnt   = '0;
                    d.err   = word_fault;
                    d.tt    = time_base;
                    d.mre   = 1'b1;
                    d.raddr = q.blk + A_CTRL;
                    d.st    = ST_F1;
                end else if (acc_sync) begin
                    d.st = ST_SKIP;
                end
            end
            ST_SKIP: if (gap_exp) d.st = ST_IDLE;
            ST_F1: begin
                d.mre   = 1'b1;
                d.raddr = q.blk + A_DPTR;
                d.st    = ST_F2;
            end
            ST_F2: begin
                d.iwa   = mem_rdata[CB_IWA];
                d.mre   = 1'b1;
                d.raddr = q.blk + A_TAIL;
                d.st    = ST_F3;
            end
            ST_F3: begin
                d.dptr = mem_rdata[ADDR_W-1:0];
                d.st   = ST_F4;
            end
            ST_F4: begin
                d.tail  = mem_rdata[ADDR_W-1:0];
                d.mwe   = 1'b1;
                d.waddr = q.blk + A_CTRL;
                d.wdata = ctrl_word(q.tt, 1'b1, 1'b0, q.iwa);
                d.st    = cmd_is_tx(q.c1) ? ST_STS1 : ST_FIRST;
            end
            ST_FIRST, ST_DATA: begin
                if (acc_data) begin
                    d.mwe   = 1'b1;
                    d.waddr = q.dptr + ADDR_W'(q.cnt);
                    d.wdata = word_data;
                    d.cnt   = q.cnt + 6'd1;
                    d.err   = q.err | word_fault;
                    d.st    = ST_DATA;
                    if (q.cnt + 6'd1 == exp_n) d.st = fin_sts ? ST_STSF : ST_WB;
                end else if (acc_sync && q.st == ST_FIRST) begin
                    d.c2   = word_data;
                    d.rtrt = 1'b1;
                    d.err  = q.err | word_fault;
                    d.st   = ST_STS1;
                end else if (acc_sync) begin
                    d.err = 1'b1;
                    if (fin_sts) begin
                        if (q.rtrt) d.s2 = word_data;
                        else        d.s1 = word_data;
                    end
                    d.st = ST_WB;
                end else if (gap_exp) begin
                    d.err = 1'b1;
                    d.st  = ST_WB;
                end
            end
            ST_STS1: begin
                if (acc_sync) begin
                    d.s1  = word_data;
                    d.err = q.err | word_fault;
                    d.st  = ST_DATA;
                end else if (acc_data || gap_exp) begin
                    d.err = 1'b1;
                    d.st  = ST_WB;
                end
            end
            ST_STSF: begin
                if (acc_sync) begin
                    if (q.rtrt) d.s2 = word_data;
                    else        d.s1 = word_data;
                    d.err = q.err | word_fault;
                    d.st  = ST_WB;
                end else if (acc_data) begin
                    d.err = 1'b1;
                end else if (gap_exp) begin
                    d.err = 1'b1;
                    d.st  = ST_WB;
                end
            end
            ST_WB: begin
                d.mwe = 1'b1;
                d.wbi = q.wbi + 3'd1;
                unique case (q.wbi)
                    3'd0:    begin d.waddr = q.blk + A_CMD1; d.wdata = q.c1; end
                    3'd1:    begin d.waddr = q.blk + A_CMD2; d.wdata = q.c2; end
                    3'd2:    begin d.waddr = q.blk + A_STS1; d.wdata = q.s1; end
                    3'd3:    begin d.waddr = q.blk + A_STS2; d.wdata = q.s2; end
                    default: begin
                        d.waddr = q.blk + A_CTRL;
                        d.wdata = ctrl_word(q.tt, 1'b1, q.err, q.iwa);
                        d.wbi   = '0;
                        d.st    = ST_FIN;
                    end
                endcase
            end
            ST_FIN: begin
                d.irq = q.iwa;
                d.blk = q.tail;
                d.st  = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
        if (!mon_en) begin
            d.st  = ST_IDLE;
            d.blk = list_head;
            d.wbi = '0;
            d.mre = 1'b0;
            d.mwe = 1'b0;
            d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_re    = q.mre;
    assign mem_raddr = q.raddr;
    assign mem_we    = q.mwe;
    assign mem_waddr = q.waddr;
    assign mem_wdata = q.wdata;
    assign irq       = q.irq;
endmodule

// File: rtl/mon_logger_chk.sv
module mon_logger_chk
    import mon_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mon_en,
    input logic              word_valid,
    input logic              word_sync,
    input state_e            st_q,
    input logic              mem_re,
    input logic              mem_we,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              irq
);
    // R9: the pulse follows a control word write that is active and requested the interrupt
    p_irq_after_ctrl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(mem_we) && $past(mem_wdata[CB_ACT]) && $past(mem_wdata[CB_IWA])));

    // R9: the pulse lasts a single cycle
    p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R11: disabled logger stays off the memory and the interrupt line
    p_quiet_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |=> (!mem_we && !mem_re && !irq));

    // R10: a data word seen while idle never produces a write
    p_idle_data_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_en && st_q == ST_IDLE && word_valid && !word_sync) |=> !mem_we);
endmodule

bind mon_logger mon_logger_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mon_en     (mon_en),
    .word_valid (word_valid),
    .word_sync  (word_sync),
    .st_q       (q.st),
    .mem_re     (mem_re),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .irq        (irq)
);

// File: tb/mon_logger_tb_top.sv
`timescale 1ns/1ps
module mon_logger_tb_top;
    localparam int AW  = 10;
    localparam int GAP = 24;
    localparam int SP  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mon_en = 1'b0;
    logic [AW-1:0] list_head = '0;
    logic [31:0]   rt_enable = 32'h0000_0228;
    logic [7:0]    tbase = 8'h00;
    logic          word_valid = 1'b0;
    logic          word_sync = 1'b0;
    logic          word_fault = 1'b0;
    logic [15:0]   word_data = '0;
    logic          mem_re;
    logic [AW-1:0] mem_raddr;
    logic [15:0]   mem_rdata = '0;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [15:0]   mem_wdata;
    logic          irq;

    logic [15:0] mem [0:(1<<AW)-1];

    int checks = 0, errors = 0, wr_seen = 0, irq_seen = 0, irq_exp = 0, bi = 0;
    bit finished = 1'b0;
    logic [AW-1:0] q_addr[$];
    logic [15:0]   q_data[$];
    string         q_tag[$];

    always #2.5 clk = ~clk;

    mon_logger #(.ADDR_W(AW), .GAP_CYCLES(GAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .list_head(list_head),
        .rt_enable(rt_enable), .time_base(tbase), .word_valid(word_valid),
        .word_sync(word_sync), .word_fault(word_fault), .word_data(word_data),
        .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .irq(irq)
    );

    always @(posedge clk) begin
        tbase <= tbase + 8'd1;
        if (mem_re) mem_rdata <= mem[mem_raddr];
        if (mem_we) mem[mem_waddr] <= mem_wdata;
    end

    function automatic logic [AW-1:0] blk_a(input int i);
        return AW'(64 + 8 * i);
    endfunction
    function automatic logic [AW-1:0] dptr_a(input int i);
        return AW'(256 + 40 * i);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // scoreboard monitor: every write must match the next expected item
    always @(negedge clk) begin : mon_blk
        logic [AW-1:0] ea;
        logic [15:0]   ed;
        string         et;
        if (rst_n) begin
            if (irq) irq_seen++;
            if (mem_we) begin
                wr_seen++;
                checks++;
                if (q_addr.size() == 0) begin
                    errors++;
                    $display("FAIL unexpected write: actual addr %0h data %0h expected no write",
                             mem_waddr, mem_wdata);
                end else begin
                    ea = q_addr.pop_front();
                    ed = q_data.pop_front();
                    et = q_tag.pop_front();
                    if (mem_waddr !== ea || mem_wdata !== ed) begin
                        errors++;
                        $display("FAIL %s write: actual addr %0h data %0h expected addr %0h data %0h",
                                 et, mem_waddr, mem_wdata, ea, ed);
                    end
                end
            end
        end
    end

    task automatic push(input logic [AW-1:0] a, input logic [15:0] dv, input string t);
        q_addr.push_back(a);
        q_data.push_back(dv);
        q_tag.push_back(t);
    endtask

    // called at a falling edge
    task automatic put_word(input bit s, input logic [15:0] w, input bit f);
        word_valid = 1'b1;
        word_sync  = s;
        word_data  = w;
        word_fault = f;
        @(negedge clk);
        word_valid = 1'b0;
        word_sync  = 1'b0;
        word_fault = 1'b0;
        repeat (SP - 1) @(negedge clk);
    endtask

    function automatic logic [15:0] ctrl_exp(input logic [7:0] tt, input bit err, input bit iwa);
        return {tt, 5'b0, 1'b1, err, iwa};
    endfunction

    // kind: 0 controller-to-terminal, 1 terminal-to-controller, 2 terminal-to-terminal
    task automatic run_msg(input int kind, input logic [4:0] rt, input logic [4:0] wcf,
                           input int nd, input bit stat, input int bad, input string tag);
        logic [15:0] c1, c2, s_tx, s_fin, e_c2, e_s1, e_s2;
        logic [7:0]  tt;
        int          ex, nst;
        bit          err, mon, iwa;
        logic [4:0]  rt2;
        rt2   = 5'd9;
        c1    = {rt, (kind == 1), 5'd1, wcf};
        c2    = {rt2, 1'b1, 5'd2, wcf};
        s_tx  = (kind == 2) ? {rt2, 11'h010} : {rt, 11'h010};
        s_fin = {rt, 11'h004};
        ex    = (wcf == 5'd0) ? 32 : int'(wcf);
        nst   = (nd < ex) ? nd : ex;
        err   = (nd != ex) || (!stat && kind != 1) || (bad >= 0 && bad < nst);
        mon   = rt_enable[rt];
        iwa   = bi[0];
        e_c2  = (kind == 2) ? c2 : 16'h0;
        e_s1  = (kind == 0) ? (stat ? s_fin : 16'h0) : s_tx;
        e_s2  = (kind == 2 && stat) ? s_fin : 16'h0;
        @(negedge clk);
        tt = tbase;
        if (mon) begin
            push(blk_a(bi), ctrl_exp(tt, 1'b0, iwa), "R5");
            for (int k = 0; k < nst; k++)
                push(dptr_a(bi) + AW'(k), {4'hD, 4'(bi), 8'(k)}, (tag == "R4") ? "R4" : "R2");
            push(blk_a(bi) + AW'(1), c1, "R1");
            push(blk_a(bi) + AW'(2), e_c2, "R6");
            push(blk_a(bi) + AW'(4), e_s1, "R1");
            push(blk_a(bi) + AW'(5), e_s2, "R6");
            push(blk_a(bi), ctrl_exp(tt, err, iwa), tag);
        end
        put_word(1'b1, c1, 1'b0);
        if (kind == 2) put_word(1'b1, c2, 1'b0);
        if (kind != 0) put_word(1'b1, s_tx, 1'b0);
        for (int k = 0; k < nd; k++)
            put_word(1'b0, {4'hD, 4'(bi), 8'(k)}, (k == bad));
        if (kind != 1 && stat) put_word(1'b1, s_fin, 1'b0);
        repeat (60) @(negedge clk);
        if (mon) begin
            if (iwa) irq_exp++;
            bi++;
        end
        check(q_addr.size() == 0, tag, "pending expected writes", q_addr.size(), 0);
        check(irq_seen == irq_exp, "R9", "interrupt count", irq_seen, irq_exp);
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int w0;
        for (int i = 0; i < (1 << AW); i++) mem[i] = 16'h0;
        for (int i = 0; i < 8; i++) begin
            mem[blk_a(i)]         = {15'h0, 1'(i % 2)};
            mem[blk_a(i) + AW'(3)] = 16'(dptr_a(i));
            mem[blk_a(i) + AW'(6)] = 16'(blk_a(i + 1));
        end
        list_head = blk_a(0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_we == 1'b0 && mem_re == 1'b0, "R11", "memory strobes after reset",
              {mem_we, mem_re}, 0);
        check(irq == 1'b0, "R9", "irq after reset", irq, 0);
        mon_en = 1'b1;
        repeat (3) @(negedge clk);

        run_msg(0, 5'd3, 5'd2, 2, 1'b1, -1, "R1");
        run_msg(1, 5'd5, 5'd3, 3, 1'b1, -1, "R2");
        run_msg(2, 5'd3, 5'd4, 4, 1'b1, -1, "R6");

        // R7: disabled terminal, no writes, block 3 stays next
        w0 = wr_seen;
        run_msg(0, 5'd7, 5'd2, 2, 1'b1, -1, "R7");
        check(wr_seen == w0, "R7", "writes for disabled terminal", wr_seen - w0, 0);

        // R10: stray data words while idle
        w0 = wr_seen;
        @(negedge clk);
        put_word(1'b0, 16'h1234, 1'b0);
        put_word(1'b0, 16'h5678, 1'b0);
        repeat (10) @(negedge clk);
        check(wr_seen == w0, "R10", "writes for idle data words", wr_seen - w0, 0);

        run_msg(0, 5'd9, 5'd0, 32, 1'b1, -1, "R4");
        run_msg(0, 5'd3, 5'd3, 3, 1'b0, -1, "R8");
        run_msg(0, 5'd5, 5'd2, 2, 1'b1, 1, "R8");
        run_msg(0, 5'd3, 5'd4, 2, 1'b1, -1, "R8");

        // R11: relocate the list head while disabled
        @(negedge clk);
        mon_en    = 1'b0;
        list_head = blk_a(2);
        repeat (3) @(negedge clk);
        check(mem_we == 1'b0 && irq == 1'b0, "R11", "quiet while disabled", {mem_we, irq}, 0);
        mon_en = 1'b1;
        bi     = 2;
        repeat (2) @(negedge clk);
        run_msg(1, 5'd9, 5'd1, 1, 1'b1, -1, "R11");
        run_msg(0, 5'd3, 5'd1, 1, 1'b1, -1, "R3");
        run_msg(0, 5'd5, 5'd1, 1, 1'b1, -1, "R5");

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule